// File: doc/BRIEF.md
# PMIC Register Access Bridge

This bridge gives a processor access to the 16-bit registers of a companion power-management chip. The processor sees a memory-mapped register page and a slave window. A store into the window is queued in a small write FIFO. A sequencer drains the FIFO and sends each entry over a four-wire serial link. A read starts when software stores a register offset into the read-command register. No separate start bit is needed. Software then polls the read-data register until its busy flag drops.

Each read reply carries two values: the register value, and the register index as the slave echoed it back. Software compares the echoed index with the one it asked for, and so can detect a reply that went to the wrong register or was corrupted on the link. Reads are held back until the write FIFO is empty, so a read always observes every write that was queued before it. The FIFO full and empty flags can be read by software, and a dropped write leaves a sticky overflow flag.

Register page (byte offsets from the bridge base): status at 0x0000, read command at 0x0004, read data at 0x0008. The slave window starts at 0x8000 and spans 4 << ADDR_BITS bytes, which is 4 KiB with the default ADDR_BITS = 10. A slave register index is the window byte offset shifted right by two. The two low address bits never reach the link.

Top module: `pmic_bridge`

## Requirements
- R1: After reset, the status register reads 0x0000_0400 (empty set, full and overflow clear) and the read-data register reads 0. The serial chip select is high and the serial clock is low.
- R2: A bus write inside the window sends one 32-bit frame, most significant bit first: a 0 bit (write), then the 15-bit register index, then wdata[15:0]. The slave samples each bit on the rising serial-clock edge, and the data output changes only while the serial clock is low.
- R3: Writing a byte offset to the read command sets bit 31 (busy) of the read-data register. The set is seen by the next bus read. When the read finishes, busy clears. Bits 15:0 then hold the value returned by the slave, and bits 30:16 hold the index the slave echoed, not the index that was requested.
- R4: A read frame has two parts. The bridge first sends 16 bits: a 1 bit (read), then the 15-bit index. It then takes in 31 reply bits (echoed index, then data, MSB first), each sampled on the falling serial-clock edge. The serial clock stays low whenever chip select is high.
- R5: Status bit 11 reports FIFO full and bit 10 reports FIFO empty. The two are never set together.
- R6: A window write that arrives while the FIFO is full is dropped and never reaches the slave. It sets the sticky overflow flag in status bit 0. Writing 1 to status bit 0 clears that flag.
- R7: A pending read does not start while the write FIFO holds entries. A read issued right after queued writes to the same register returns the last value written.
- R8: A read command written while busy is set is ignored. The running read keeps its index and returns its own result.
- R9: Bus writes outside the window (below 0x8000, or at or above 0x8000 + window size) send nothing. A read command whose offset is at or beyond the window size is ignored, and busy stays clear.
- R10: The two low bits of a window address or a read-command offset are ignored. Byte offsets 0x50 to 0x53 all select index 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe; data appears on bus_rdata one cycle later |
| bus_addr | input | BUS_AW | Bus byte address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered bus read data |
| ser_sclk | output | 1 | Serial clock, low when idle |
| ser_cs_n | output | 1 | Serial chip select, active low |
| ser_sdo | output | 1 | Serial data to the slave |
| ser_sdi | input | 1 | Serial data from the slave |

## Verification
The hardest case to reach is a read command that is accepted while writes to the same register are still queued behind a frame that is already shifting. The read must wait for both writes and return the later value. The bench issues two back-to-back window writes and then the read command at once. Because one serial frame lasts far longer than a bus write, the FIFO still holds an entry when the command lands. The overflow case uses the same effect: six fast writes fill a four-entry FIFO behind one running frame, and the bench then checks that the dropped write never changed the slave register.

// File: rtl/pmic_bridge_pkg.sv
package pmic_bridge_pkg;

  localparam int SER_AW     = 15;
  localparam int SER_DW     = 16;
  localparam int CMD_BITS   = 1 + SER_AW;
  localparam int REPLY_BITS = SER_AW + SER_DW;
  localparam int WR_BITS    = 1 + SER_AW + SER_DW;

  typedef struct packed {
    logic [SER_AW-1:0] addr;
    logic [SER_DW-1:0] data;
  } wr_entry_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_WRITE,
    SEQ_READ
  } seq_state_t;

endpackage

// File: rtl/pmic_wfifo.sv
module pmic_wfifo #(
  parameter int DEPTH = 4,
  parameter int W     = 31
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         full,
  output logic         empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  typedef logic [PW:0]   cnt_t;
  typedef logic [PW-1:0] ptr_t;
  localparam cnt_t FULL_CNT = cnt_t'(DEPTH);
  localparam ptr_t LAST_PTR = ptr_t'(DEPTH - 1);

  logic [W-1:0] mem [DEPTH];
  ptr_t wr_ptr, rd_ptr;
  cnt_t count;
  logic push_ok, pop_ok;

  assign full     = (count == FULL_CNT);
  assign empty    = (count == '0);
  assign push_ok  = push && !full;
  assign pop_ok   = pop && !empty;
  assign pop_data = mem[rd_ptr];

  // storage without reset so the array can map onto RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R5
  flags_excl_chk: assert property (@(posedge clk) disable iff (rst) !(full && empty));
  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (rst) count <= FULL_CNT);

endmodule

// File: rtl/pmic_serial.sv
module pmic_serial
  import pmic_bridge_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  is_rd,
  input  logic [SER_AW-1:0]     addr,
  input  logic [SER_DW-1:0]     data,
  output logic                  busy,
  output logic                  done,
  output logic [REPLY_BITS-1:0] reply,
  output logic                  sclk,
  output logic                  cs_n,
  output logic                  sdo,
  input  logic                  sdi
);

  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  typedef logic [DW-1:0] div_t;
  typedef logic [5:0]    bit_t;
  localparam div_t DIV_LAST = div_t'(HALF_DIV - 1);
  localparam bit_t CMD_END  = bit_t'(CMD_BITS);
  localparam bit_t LAST_WR  = bit_t'(WR_BITS - 1);
  localparam bit_t LAST_RD  = bit_t'(CMD_BITS + REPLY_BITS - 1);

  logic [WR_BITS-1:0]    sh_out;
  logic [REPLY_BITS-1:0] sh_in;
  logic                  active, rd_q;
  bit_t                  bit_cnt, last_bit;
  div_t                  div_cnt;

  assign busy     = active;
  assign reply    = sh_in;
  assign sdo      = sh_out[WR_BITS-1];
  assign last_bit = rd_q ? LAST_RD : LAST_WR;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      rd_q    <= 1'b0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      done    <= 1'b0;
      sh_out  <= '0;
      sh_in   <= '0;
      bit_cnt <= '0;
      div_cnt <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          cs_n    <= 1'b0;
          sclk    <= 1'b0;
          rd_q    <= is_rd;
          sh_out  <= {is_rd, addr, is_rd ? '0 : data};
          sh_in   <= '0;
          bit_cnt <= '0;
          div_cnt <= '0;
        end
      end else if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        if (!sclk) begin
          sclk <= 1'b1;
        end else begin
          sclk <= 1'b0;
          if (rd_q && bit_cnt >= CMD_END) sh_in <= {sh_in[REPLY_BITS-2:0], sdi};
          if (bit_cnt == last_bit) begin
            active <= 1'b0;
            cs_n   <= 1'b1;
            done   <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            sh_out  <= {sh_out[WR_BITS-2:0], 1'b0};
          end
        end
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  // R4
  idle_clk_low_chk: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sclk);
  // R2
  sdo_hold_chk: assert property (@(posedge clk) disable iff (rst) sclk |-> $stable(sdo));

endmodule

// File: rtl/pmic_seq.sv
module pmic_seq
  import pmic_bridge_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fifo_empty,
  input  wr_entry_t             fifo_head,
  output logic                  fifo_pop,
  input  logic                  cmd_wr,
  input  logic [SER_AW-1:0]     cmd_addr,
  input  logic                  eng_busy,
  input  logic                  eng_done,
  input  logic [REPLY_BITS-1:0] eng_reply,
  output logic                  eng_start,
  output logic                  eng_is_rd,
  output logic [SER_AW-1:0]     eng_addr,
  output logic [SER_DW-1:0]     eng_data,
  output logic                  rd_busy,
  output logic [REPLY_BITS-1:0] rd_result
);

  seq_state_t        state;
  logic [SER_AW-1:0] rd_addr_q;

  assign fifo_pop = (state == SEQ_IDLE) && !eng_busy && !fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SEQ_IDLE;
      rd_busy   <= 1'b0;
      rd_addr_q <= '0;
      rd_result <= '0;
      eng_start <= 1'b0;
      eng_is_rd <= 1'b0;
      eng_addr  <= '0;
      eng_data  <= '0;
    end else begin
      eng_start <= 1'b0;
      if (cmd_wr && !rd_busy) begin
        rd_busy   <= 1'b1;
        rd_addr_q <= cmd_addr;
      end
      case (state)
        SEQ_IDLE: begin
          if (!eng_busy) begin
            if (!fifo_empty) begin
              eng_start <= 1'b1;
              eng_is_rd <= 1'b0;
              eng_addr  <= fifo_head.addr;
              eng_data  <= fifo_head.data;
              state     <= SEQ_WRITE;
            end else if (rd_busy) begin
              eng_start <= 1'b1;
              eng_is_rd <= 1'b1;
              eng_addr  <= rd_addr_q;
              eng_data  <= '0;
              state     <= SEQ_READ;
            end
          end
        end
        SEQ_WRITE: if (eng_done) state <= SEQ_IDLE;
        SEQ_READ: begin
          if (eng_done) begin
            rd_result <= eng_reply;
            rd_busy   <= 1'b0;
            state     <= SEQ_IDLE;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R7
  read_waits_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_IDLE && !fifo_empty) |=> !(eng_start && eng_is_rd));
  // R8
  cmd_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_busy && cmd_wr) |=> $stable(rd_addr_q));

endmodule

// File: rtl/pmic_bridge.sv
module pmic_bridge
  import pmic_bridge_pkg::*;
#(
  parameter int BUS_AW     = 16,
  parameter int WIN_BASE   = 32'h8000,
  parameter int ADDR_BITS  = 10,
  parameter int FIFO_DEPTH = 4,
  parameter int HALF_DIV   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              ser_sclk,
  output logic              ser_cs_n,
  output logic              ser_sdo,
  input  logic              ser_sdi
);

  localparam int WIN_BYTES = 4 << ADDR_BITS;
  localparam logic [31:0] WIN_LO   = 32'(WIN_BASE);
  localparam logic [31:0] WIN_HI   = 32'(WIN_BASE + WIN_BYTES);
  localparam logic [31:0] WIN_SIZE = 32'(WIN_BYTES);
  localparam logic [BUS_AW-1:0] OFS_STATUS = BUS_AW'(0);
  localparam logic [BUS_AW-1:0] OFS_RDCMD  = BUS_AW'(4);
  localparam logic [BUS_AW-1:0] OFS_RDDATA = BUS_AW'(8);

  logic [31:0]           addr_ext, win_off;
  logic                  win_hit, push, cmd_wr, ovf;
  logic [SER_AW-1:0]     win_idx, cmd_idx;
  wr_entry_t             push_entry, head_entry;
  logic                  fifo_full, fifo_empty, fifo_pop;
  logic                  eng_start, eng_is_rd, eng_busy, eng_done;
  logic [SER_AW-1:0]     eng_addr;
  logic [SER_DW-1:0]     eng_data;
  logic [REPLY_BITS-1:0] eng_reply, rd_result;
  logic                  rd_busy;
  logic                  unused_bits;

  assign addr_ext = 32'(bus_addr);
  assign win_hit  = (addr_ext >= WIN_LO) && (addr_ext < WIN_HI);
  assign win_off  = addr_ext - WIN_LO;
  assign win_idx  = SER_AW'(win_off[ADDR_BITS+1:2]);
  assign cmd_idx  = SER_AW'(bus_wdata[ADDR_BITS+1:2]);
  assign push     = bus_we && win_hit && !fifo_full;
  assign cmd_wr   = bus_we && (bus_addr == OFS_RDCMD) && (bus_wdata < WIN_SIZE);
  assign push_entry = '{addr: win_idx, data: bus_wdata[SER_DW-1:0]};
  assign unused_bits = ^{win_off[31:ADDR_BITS+2], win_off[1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_we && win_hit && fifo_full) ovf <= 1'b1;
      else if (bus_we && bus_addr == OFS_STATUS && bus_wdata[0]) ovf <= 1'b0;
      if (bus_re) begin
        case (bus_addr)
          OFS_STATUS: bus_rdata <= {20'b0, fifo_full, fifo_empty, 9'b0, ovf};
          OFS_RDDATA: bus_rdata <= {rd_busy, rd_result};
          default:    bus_rdata <= '0;
        endcase
      end
    end
  end

  pmic_wfifo #(.DEPTH(FIFO_DEPTH), .W($bits(wr_entry_t))) u_fifo (
    .clk(clk), .rst(rst),
    .push(push), .push_data(push_entry),
    .pop(fifo_pop), .pop_data(head_entry),
    .full(fifo_full), .empty(fifo_empty)
  );

  pmic_seq u_seq (
    .clk(clk), .rst(rst),
    .fifo_empty(fifo_empty), .fifo_head(head_entry), .fifo_pop(fifo_pop),
    .cmd_wr(cmd_wr), .cmd_addr(cmd_idx),
    .eng_busy(eng_busy), .eng_done(eng_done), .eng_reply(eng_reply),
    .eng_start(eng_start), .eng_is_rd(eng_is_rd),
    .eng_addr(eng_addr), .eng_data(eng_data),
    .rd_busy(rd_busy), .rd_result(rd_result)
  );

  pmic_serial #(.HALF_DIV(HALF_DIV)) u_ser (
    .clk(clk), .rst(rst),
    .start(eng_start), .is_rd(eng_is_rd), .addr(eng_addr), .data(eng_data),
    .busy(eng_busy), .done(eng_done), .reply(eng_reply),
    .sclk(ser_sclk), .cs_n(ser_cs_n), .sdo(ser_sdo), .sdi(ser_sdi)
  );

endmodule

// File: tb/pmic_bridge_tb.sv
`timescale 1ns/1ps
module pmic_bridge_tb;

  localparam logic [15:0] A_STATUS = 16'h0000;
  localparam logic [15:0] A_RDCMD  = 16'h0004;
  localparam logic [15:0] A_RDDATA = 16'h0008;
  localparam logic [15:0] A_WIN    = 16'h8000;
  // each entry: window byte offset [31:16], write value [15:0]
  localparam logic [31:0] VEC [6] = '{
    32'h0000_0000, 32'h0004_FFFF, 32'h0FFC_A5A5,
    32'h0010_8001, 32'h0800_7FFE, 32'h03FC_1234
  };

  logic clk = 1'b0, rst = 1'b1;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sclk, cs_n, sdo, sdi;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  pmic_bridge u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_sclk(sclk), .ser_cs_n(cs_n), .ser_sdo(sdo), .ser_sdi(sdi)
  );

  // slave model: samples on rising edge, drives reply on rising edge
  logic [15:0] smem [1024];
  int s_cnt = 0, n_frames = 0;
  logic s_rw = 1'b0, corrupt = 1'b0;
  logic [14:0] s_addr = '0;
  logic [15:0] s_data = '0;
  logic [30:0] s_reply = '0;
  logic lf_rw;
  logic [14:0] lf_addr;
  logic [15:0] lf_data;

  initial begin
    sdi = 1'b0;
    for (int i = 0; i < 1024; i++) smem[i] = 16'(i) ^ 16'h5A00;
  end

  always @(posedge sclk) begin
    if (!cs_n) begin
      if (s_cnt == 0) s_rw = sdo;
      else if (s_cnt < 16) s_addr = {s_addr[13:0], sdo};
      else if (!s_rw) s_data = {s_data[14:0], sdo};
      if (s_rw && s_cnt >= 16) begin
        if (s_cnt == 16) s_reply = {s_addr ^ {14'b0, corrupt}, smem[s_addr[9:0]]};
        sdi = s_reply[30 - (s_cnt - 16)];
      end
      s_cnt++;
      if (!s_rw && s_cnt == 32) begin
        smem[s_addr[9:0]] = s_data;
        lf_rw = 1'b0; lf_addr = s_addr; lf_data = s_data;
        n_frames++; s_cnt = 0;
      end else if (s_rw && s_cnt == 47) begin
        lf_rw = 1'b1; lf_addr = s_addr; lf_data = 16'h0;
        n_frames++; s_cnt = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk); bus_re = 1'b1; bus_addr = a;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic wait_frames(input int n);
    for (int i = 0; i < 20000 && n_frames < n; i++) @(negedge clk);
  endtask

  task automatic wait_read(output logic [31:0] d);
    d = 32'h8000_0000;
    for (int i = 0; i < 2000 && d[31]; i++) bus_rd(A_RDDATA, d);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int base;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_rd(A_STATUS, r);  chk("R1 status", r, 32'h0000_0400);
    bus_rd(A_RDDATA, r);  chk("R1 rddata", r, 32'h0);
    chk("R1 serial idle", {30'b0, cs_n, sclk}, 32'h2);

    // table walk: R2 write frame, R3 read result, R4 read frame
    for (int v = 0; v < 6; v++) begin
      logic [14:0] idx;
      idx = 15'(VEC[v][31:18]);
      base = n_frames;
      bus_wr(A_WIN + VEC[v][31:16], {16'h0, VEC[v][15:0]});
      wait_frames(base + 1);
      chk("R2 write frame", {lf_rw, lf_addr, lf_data}, {1'b0, idx, VEC[v][15:0]});
      bus_wr(A_RDCMD, {16'h0, VEC[v][31:16]});
      wait_read(r);
      chk("R3 read result", r, {1'b0, idx, VEC[v][15:0]});
      chk("R4 read frame", {16'h0, lf_rw, lf_addr}, {16'h0, 1'b1, idx});
    end

    // R3 busy seen on the very next read
    bus_wr(A_RDCMD, 32'h40);
    bus_rd(A_RDDATA, r);  chk("R3 busy set", {31'b0, r[31]}, 32'h1);
    wait_read(r);         chk("R3 default value", r, {1'b0, 15'h10, 16'h5A10});

    // R8 second command during busy is ignored
    base = n_frames;
    bus_wr(A_RDCMD, 32'h80);
    bus_wr(A_RDCMD, 32'hC0);
    wait_read(r);         chk("R8 first read kept", r, {1'b0, 15'h20, 16'h5A20});
    repeat (300) @(negedge clk);
    chk("R8 single frame", 32'(n_frames - base), 32'd1);

    // R5 R6 fill FIFO behind a running frame
    base = n_frames;
    for (int k = 1; k <= 5; k++) bus_wr(A_WIN + 16'(k * 4 + 16'hC0), 32'(16'h1000 + k));
    bus_wr(A_WIN + 16'h00C0, 32'h0000_DEAD);
    bus_rd(A_STATUS, r);  chk("R5 R6 full and overflow", r, 32'h0000_0801);
    wait_frames(base + 5);
    repeat (300) @(negedge clk);
    chk("R6 dropped write not sent", 32'(n_frames - base), 32'd5);
    bus_wr(A_RDCMD, 32'hC0);
    wait_read(r);         chk("R6 dropped value absent", r, {1'b0, 15'h30, 16'h5A30});
    bus_wr(A_STATUS, 32'h1);
    bus_rd(A_STATUS, r);  chk("R6 overflow cleared", r, 32'h0000_0400);

    // R7 read waits behind queued writes to the same register
    bus_wr(A_WIN + 16'h0100, 32'h1111);
    bus_wr(A_WIN + 16'h0100, 32'h2222);
    bus_wr(A_RDCMD, 32'h100);
    wait_read(r);         chk("R7 read after writes", r, {1'b0, 15'h40, 16'h2222});

    // R9 out-of-window accesses
    base = n_frames;
    bus_wr(16'h9000, 32'h0BEE);
    bus_wr(16'h7FFC, 32'h0BEF);
    repeat (400) @(negedge clk);
    chk("R9 no frame sent", 32'(n_frames - base), 32'd0);
    bus_wr(A_RDCMD, 32'h1000);
    bus_rd(A_RDDATA, r);  chk("R9 command ignored", r, {1'b0, 15'h40, 16'h2222});

    // R10 low address bits ignored
    base = n_frames;
    bus_wr(A_WIN + 16'h0053, 32'h0BAD);
    wait_frames(base + 1);
    chk("R10 write index", {17'h0, lf_addr}, 32'h14);
    bus_wr(A_RDCMD, 32'h52);
    wait_read(r);         chk("R10 read index", r, {1'b0, 15'h14, 16'h0BAD});

    // R3 echoed index comes from the link
    corrupt = 1'b1;
    bus_wr(A_RDCMD, 32'h40);
    wait_read(r);         chk("R3 echo from slave", r, {1'b0, 15'h11, 16'h5A10});
    corrupt = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule